// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block carries words from a writer clocked by `wclk` to a reader clocked by an unrelated `rclk`. Storage is a power-of-two array of `DW`-bit words. The write side sees a registered ready flag, and the read side sees a registered valid flag. Each flag is built from the other side's pointer, which crosses the clock boundary as a Gray code through a two-flop synchroniser. The read side works in first-word-fall-through style: when the output is idle, the first stored word moves into the output stage by itself. After that, a new word is presented only when the reader takes the current one.

The reader can pin the word it is looking at. Raising `mark_hold` while `rd_valid` is high records that word and enters replay mode. In replay mode, pulsing `mark_rewind` puts the recorded word back on the output, and the words that follow it are read again in their original order. While the mark is held, the writer is not allowed to overwrite any word from the mark onward, so its capacity is measured from the mark rather than from the live read position. Dropping `mark_hold` leaves replay mode, and the space the reader has already passed is returned to the writer.

Top module: `replay_fifo`

## Requirements
- R1: While `rst` is high at clock edges, `wr_ready` and `rd_valid` are low. After `rst` falls, `wr_ready` is still low following the first `wclk` rising edge and is high following the second.
- R2: Words leave the FIFO in the order they were accepted, with no loss and no duplication, under unrelated clock periods and irregular read pacing.
- R3: A write is accepted only on a `wclk` edge where `wr_en` and `wr_ready` are both high. Writes attempted while `wr_ready` is low leave no trace in the data read out.
- R4: When a word is written into an empty FIFO, `rd_valid` rises on the third `rclk` rising edge after the accepting `wclk` edge, with that word on `rd_data`.
- R5: While `rd_valid` is high, `rd_data` changes only on an `rclk` edge with `rd_en` or `mark_rewind` high. A read attempted while `rd_valid` is low has no effect.
- R6: An `rclk` edge that sees `mark_hold` high and `rd_valid` high records the word on `rd_data` as the mark and enters replay mode. While `rd_valid` is low, `mark_hold` does nothing. The mark stays the same for as long as `mark_hold` remains high.
- R7: In replay mode, an `rclk` edge with `mark_rewind` high makes `rd_valid` high and puts the marked word on `rd_data`. The following reads return the same sequence that followed the mark the first time.
- R8: With no reads pending, the FIFO accepts `DEPTH`+1 words: `DEPTH` in the array and one in the output stage. While the mark is held, the writer accepts at most `DEPTH` words beyond the marked one, and reading them does not raise `wr_ready`.
- R9: An `rclk` edge with `mark_hold` low leaves replay mode. The space already read past is then released, so `wr_ready` rises again. After that, `mark_rewind` has no effect.
- R10: The write pointer and the writer's limit pointer each cross the clock boundary as Gray codes that change by at most one bit per source clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock, unrelated to `wclk` |
| rst | input | 1 | Synchronous active-high reset, held for at least four edges of each clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_ready | output | 1 | Space available; a write is accepted only when this is high |
| rd_en | input | 1 | Take the word on `rd_data` |
| rd_data | output | DW | Word at the head of the FIFO, or the marked word just after a rewind |
| rd_valid | output | 1 | `rd_data` holds a valid word |
| mark_hold | input | 1 | High: record the current output word and stay in replay mode. Low: leave replay mode |
| mark_rewind | input | 1 | In replay mode, rewind the read side to the marked word |

## Verification
The hardest state to reach is a held mark combined with a writer stopped at the mark limit instead of at the live read position. The writer is blocked because the marked word and everything after it must survive, not because unread data fills the array. To get there, the bench holds `mark_hold` high on an empty FIFO, writes a single word so that the mark falls on it automatically, and then keeps writing until `wr_ready` drops. Reading out the whole array then shows that `wr_ready` stays low. A rewind replays all `DEPTH`+1 words, and releasing the mark is the only action that returns the space.

// File: rtl/replay_fifo_pkg.sv
`timescale 1ns/1ps
package replay_fifo_pkg;
  localparam int PMAX = 32;

  function automatic logic [PMAX-1:0] to_gray(input logic [PMAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PMAX-1:0] from_gray(input logic [PMAX-1:0] g);
    logic [PMAX-1:0] b;
    b = g;
    for (int i = PMAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/replay_sync.sv
`timescale 1ns/1ps
module replay_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/replay_mem.sv
`timescale 1ns/1ps
module replay_mem #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/replay_wr_ctrl.sv
`timescale 1ns/1ps
module replay_wr_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] lim_gray,
  output logic        wr_ready,
  output logic        we,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wptr_gray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr, wptr_nxt, lim_bin, fill_nxt;
  logic          boot_q, ready_q, accept;

  assign lim_bin  = PW'(from_gray(PMAX'(lim_gray)));
  assign accept   = wr_en & ready_q;
  assign wptr_nxt = wptr + PW'(accept);
  assign fill_nxt = wptr_nxt - lim_bin;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
      boot_q    <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      wptr      <= wptr_nxt;
      wptr_gray <= PW'(to_gray(PMAX'(wptr_nxt)));
      boot_q    <= 1'b1;
      ready_q   <= boot_q & (fill_nxt != PW'(DEPTH));
    end
  end

  assign wr_ready = ready_q;
  assign we       = accept;
  assign waddr    = wptr[AW-1:0];
endmodule

// File: rtl/replay_rd_ctrl.sv
`timescale 1ns/1ps
module replay_rd_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          mark_hold,
  input  logic          mark_rewind,
  input  logic [AW:0]   wq_gray,
  input  logic [DW-1:0] ram_q,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW:0]   lim_gray
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr, mark_ptr, lim, lim_tgt, lim_nxt, wq_bin;
  logic [DW-1:0] mark_word;
  logic          valid_q, show_mark, replay;
  logic          take, rewind, avail, load, enter;

  assign wq_bin  = PW'(from_gray(PMAX'(wq_gray)));
  assign take    = rd_en & valid_q;
  assign rewind  = replay & mark_hold & mark_rewind;
  assign avail   = (wq_bin != rptr);
  assign load    = ~rewind & avail & (~valid_q | take);
  assign enter   = ~replay & mark_hold & valid_q;

  // The writer's limit only ever steps forward by one, so its Gray code moves one bit.
  assign lim_tgt = replay ? mark_ptr : rptr;
  assign lim_nxt = (lim != lim_tgt) ? lim + PW'(1) : lim;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rptr      <= '0;
      valid_q   <= 1'b0;
      show_mark <= 1'b0;
      replay    <= 1'b0;
      mark_ptr  <= '0;
      mark_word <= '0;
      lim       <= '0;
      lim_gray  <= '0;
    end else begin
      if (rewind) begin
        rptr      <= mark_ptr;
        valid_q   <= 1'b1;
        show_mark <= 1'b1;
      end else if (load) begin
        rptr      <= rptr + PW'(1);
        valid_q   <= 1'b1;
        show_mark <= 1'b0;
      end else if (take) begin
        valid_q   <= 1'b0;
      end

      if (!mark_hold) begin
        replay <= 1'b0;
      end else if (enter) begin
        replay    <= 1'b1;
        mark_ptr  <= rptr;
        mark_word <= rd_data;
      end

      lim      <= lim_nxt;
      lim_gray <= PW'(to_gray(PMAX'(lim_nxt)));
    end
  end

  assign ram_re   = load;
  assign ram_addr = rptr[AW-1:0];
  assign rd_data  = show_mark ? mark_word : ram_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/replay_fifo.sv
`timescale 1ns/1ps
module replay_fifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          mark_hold,
  input  logic          mark_rewind
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_gray, wq_gray, lim_gray, lq_gray;
  logic          we, ram_re;
  logic [AW-1:0] waddr, ram_addr;
  logic [DW-1:0] ram_q;

  replay_wr_ctrl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst(rst), .wr_en(wr_en), .lim_gray(lq_gray),
    .wr_ready(wr_ready), .we(we), .waddr(waddr), .wptr_gray(wptr_gray)
  );

  replay_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst(rst), .d(wptr_gray), .q(wq_gray)
  );

  replay_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst(rst), .d(lim_gray), .q(lq_gray)
  );

  replay_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(ram_re), .raddr(ram_addr), .rdata(ram_q)
  );

  replay_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst(rst), .rd_en(rd_en), .mark_hold(mark_hold),
    .mark_rewind(mark_rewind), .wq_gray(wq_gray), .ram_q(ram_q),
    .ram_re(ram_re), .ram_addr(ram_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .lim_gray(lim_gray)
  );
endmodule

// File: rtl/replay_fifo_chk.sv
`timescale 1ns/1ps
module replay_fifo_chk
  import replay_fifo_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_ready,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          mark_hold,
  input logic          mark_rewind,
  input logic [AW:0]   wptr_gray,
  input logic [AW:0]   lim_gray,
  input logic [AW:0]   lq_gray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          past_w, past_r;
  logic [PW-1:0] w_bin, l_bin, w_fill;

  always_ff @(posedge wclk) past_w <= rst ? 1'b0 : 1'b1;
  always_ff @(posedge rclk) past_r <= rst ? 1'b0 : 1'b1;

  assign w_bin  = PW'(from_gray(PMAX'(wptr_gray)));
  assign l_bin  = PW'(from_gray(PMAX'(lq_gray)));
  assign w_fill = w_bin - l_bin;

  assert_blocked_write_R3: assert property (@(posedge wclk) disable iff (rst)
    (past_w && !wr_ready) |=> $stable(wptr_gray));

  assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (rst)
    past_w |-> (w_fill <= PW'(DEPTH)));

  assert_wgray_step_R10: assert property (@(posedge wclk) disable iff (rst)
    past_w |-> ($countones(wptr_gray ^ $past(wptr_gray)) <= 1));

  assert_lgray_step_R10: assert property (@(posedge rclk) disable iff (rst)
    past_r |-> ($countones(lim_gray ^ $past(lim_gray)) <= 1));

  assert_output_hold_R5: assert property (@(posedge rclk) disable iff (rst)
    (past_r && rd_valid && !rd_en && !mark_rewind) |=> (rd_valid && $stable(rd_data)));

  assert_rewind_valid_R7: assert property (@(posedge rclk) disable iff (rst)
    (past_r && mark_hold && mark_rewind && $past(mark_hold) && $past(rd_valid)) |=> rd_valid);
endmodule

bind replay_fifo replay_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_ready(wr_ready),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .mark_hold(mark_hold), .mark_rewind(mark_rewind),
  .wptr_gray(wptr_gray), .lim_gray(lim_gray), .lq_gray(lq_gray)
);

// File: tb/replay_fifo_bench.sv
`timescale 1ns/1ps
module replay_fifo_bench;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst  = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          mark_hold = 1'b0;
  logic          mark_rewind = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  replay_fifo #(.DW(DW), .AW(AW)) u_replay_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .mark_hold(mark_hold), .mark_rewind(mark_rewind)
  );

  // 100 MHz write clock; read clock of 14 ns whose rising edges fall on even ns only.
  initial forever #5 wclk = ~wclk;
  initial begin
    #2 rclk = 1'b1;
    forever #7 rclk = ~rclk;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; mark_hold = 1'b0; mark_rewind = 1'b0;
    repeat (8) @(negedge wclk);
    #1 rst = 1'b0;
    repeat (4) @(negedge wclk);
  endtask

  task automatic write_try(input logic [DW-1:0] v, output bit acc);
    @(negedge wclk);
    acc = wr_ready;
    wr_en = 1'b1; wr_data = v;
    @(posedge wclk);
    #1 wr_en = 1'b0;
  endtask

  task automatic read_one(output logic [DW-1:0] d, output bit got, input int tmo);
    got = 1'b0; d = '0;
    for (int t = 0; t < tmo; t++) begin
      @(negedge rclk);
      if (rd_valid) begin
        d = rd_data; got = 1'b1; rd_en = 1'b1;
        @(posedge rclk);
        #1 rd_en = 1'b0;
        break;
      end
    end
  endtask

  task automatic rclk_pulse_rewind();
    @(negedge rclk) mark_rewind = 1'b1;
    @(posedge rclk);
    #1 mark_rewind = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(32'h5A00_0000 + i * 7);
  endfunction

  task automatic t_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; mark_hold = 1'b0; mark_rewind = 1'b0;
    repeat (8) @(negedge wclk);
    check(wr_ready == 1'b0, "R1 ready in reset", 64'(wr_ready), 0);
    check(rd_valid == 1'b0, "R1 valid in reset", 64'(rd_valid), 0);
    #1 rst = 1'b0;
    @(negedge wclk);
    check(wr_ready == 1'b0, "R1 ready after 1 edge", 64'(wr_ready), 0);
    @(negedge wclk);
    check(wr_ready == 1'b1, "R1 ready after 2 edges", 64'(wr_ready), 1);
  endtask

  task automatic t_latency_and_empty_read();
    logic [DW-1:0] d;
    bit got;
    do_reset();
    // R5: reads with nothing valid do nothing
    @(negedge rclk) rd_en = 1'b1;
    repeat (6) @(negedge rclk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0, "R5 empty read", 64'(rd_valid), 0);
    // R4: latency of the first word
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 32'hCAFE_0001;
    @(posedge wclk);
    #1 wr_en = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge rclk);
      #1;
      check(rd_valid == (e == 3), "R4 valid edge", 64'(rd_valid), 64'(e == 3));
    end
    check(rd_data == 32'hCAFE_0001, "R4 first word", 64'(rd_data), 64'hCAFE_0001);
    read_one(d, got, 10);
    read_one(d, got, 20);
    check(!got, "R5 no duplicate", 64'(got), 0);
  endtask

  task automatic t_stream();
    bit acc;
    do_reset();
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          acc = 1'b0;
          while (!acc) write_try(pat(i), acc);
        end
      end
      begin
        logic [DW-1:0] d;
        bit got;
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
          if (i % 5 == 0) repeat (3) @(negedge rclk);
          read_one(d, got, 200);
          if (!got || d != pat(i)) begin
            bad++;
            check(1'b0, "R2 stream order", 64'(d), 64'(pat(i)));
          end
        end
        check(bad == 0, "R2 stream complete", 64'(bad), 0);
      end
    join
  endtask

  task automatic t_full();
    bit acc;
    int n_acc = 0;
    logic [DW-1:0] d;
    bit got;
    int bad = 0;
    do_reset();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      write_try(pat(100 + i), acc);
      if (acc) n_acc++;
    end
    check(n_acc == DEPTH + 1, "R8 capacity", 64'(n_acc), 64'(DEPTH + 1));
    check(wr_ready == 1'b0, "R3 ready low when full", 64'(wr_ready), 0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      read_one(d, got, 50);
      if (!got || d != pat(100 + i)) bad++;
    end
    check(bad == 0, "R3 only accepted words", 64'(bad), 0);
    read_one(d, got, 20);
    check(!got, "R3 ignored writes absent", 64'(got), 0);
  endtask

  task automatic t_mark_rewind();
    bit acc;
    logic [DW-1:0] d;
    bit got;
    int bad = 0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      acc = 1'b0;
      while (!acc) write_try(pat(200 + i), acc);
    end
    for (int t = 0; t < 50 && !rd_valid; t++) @(negedge rclk);
    @(negedge rclk) mark_hold = 1'b1;
    @(posedge rclk);
    for (int i = 0; i < 4; i++) begin
      read_one(d, got, 20);
      if (!got || d != pat(200 + i)) bad++;
    end
    check(bad == 0, "R2 before rewind", 64'(bad), 0);
    @(negedge rclk);
    check(rd_valid && rd_data == pat(204), "R5 head after reads", 64'(rd_data), 64'(pat(204)));
    rclk_pulse_rewind();
    @(negedge rclk);
    check(rd_valid && rd_data == pat(200), "R7 rewind shows mark", 64'(rd_data), 64'(pat(200)));
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      read_one(d, got, 20);
      if (!got || d != pat(200 + i)) bad++;
    end
    check(bad == 0, "R7 replay sequence", 64'(bad), 0);
    rclk_pulse_rewind();
    @(negedge rclk);
    check(rd_data == pat(200), "R6 mark unchanged", 64'(rd_data), 64'(pat(200)));
    @(negedge rclk) mark_hold = 1'b0;
    @(posedge rclk);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      read_one(d, got, 20);
      if (!got || d != pat(200 + i)) bad++;
    end
    check(bad == 0, "R2 drain after release", 64'(bad), 0);
    read_one(d, got, 20);
    check(!got, "R2 drained", 64'(got), 0);
  endtask

  task automatic t_mark_limit();
    bit acc;
    int n_acc = 0;
    logic [DW-1:0] d;
    bit got;
    int bad = 0;
    do_reset();
    // R6: mark_hold with nothing valid must not enter replay mode
    @(negedge rclk) mark_hold = 1'b1;
    repeat (3) @(negedge rclk);
    rclk_pulse_rewind();
    repeat (3) @(negedge rclk);
    check(rd_valid == 1'b0, "R6 no mark when empty", 64'(rd_valid), 0);
    write_try(pat(300), acc);
    for (int t = 0; t < 50 && !rd_valid; t++) @(negedge rclk);
    @(posedge rclk);                 // mark taken on the marked word here
    repeat (10) @(negedge wclk);
    for (int i = 0; i < 3 * DEPTH; i++) begin
      write_try(pat(301 + i), acc);
      if (acc) n_acc++;
    end
    check(n_acc == DEPTH, "R8 mark-limited capacity", 64'(n_acc), 64'(DEPTH));
    for (int i = 0; i < DEPTH + 1; i++) begin
      read_one(d, got, 50);
      if (!got || d != pat(300 + i)) bad++;
    end
    check(bad == 0, "R8 first pass", 64'(bad), 0);
    repeat (20) @(negedge wclk);
    check(wr_ready == 1'b0, "R8 reads free nothing", 64'(wr_ready), 0);
    rclk_pulse_rewind();
    bad = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      read_one(d, got, 50);
      if (!got || d != pat(300 + i)) bad++;
    end
    check(bad == 0, "R7 full replay", 64'(bad), 0);
    @(negedge rclk) mark_hold = 1'b0;
    @(posedge rclk);
    repeat (40) @(negedge wclk);
    check(wr_ready == 1'b1, "R9 space released", 64'(wr_ready), 1);
    rclk_pulse_rewind();
    repeat (4) @(negedge rclk);
    check(rd_valid == 1'b0, "R9 rewind ignored", 64'(rd_valid), 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency_and_empty_read();
    t_stream();
    t_full();
    t_mark_rewind();
    t_mark_limit();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule